// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block sits in the read data path of a non-volatile memory controller. While an embedded word-program or chip-erase algorithm is running, or after such an algorithm has run past its time limit, it replaces three bits of the word returned on reads with status information. When nothing is running, array data passes through untouched.

Three status bits are produced. The polling bit shows the complement of the target value during programming and a zero during erase. The toggle bit inverts once per read access. The fail bit signals an expired time limit, and that indication is held until a reset command arrives. The toggle advances on detected read-strobe edges rather than on clock cycles, so a read that lasts many cycles still counts once. The toggle flop is cleared when each operation starts.

Top module: `pe_status_gen`

## Requirements
- R1: With no operation in progress and no pending failure, `rd_data_o` equals `arr_data_i` on every bit.
- R2: During a word program, bit 7 of `rd_data_o` is the inverse of `tgt_d7_i` as captured at the operation start (rising edge of `busy_i`).
- R3: During a chip erase (`op_erase_i`=1 at start), bit 7 of `rd_data_o` reads 0.
- R4: While status is shown, bit 6 inverts after each read access: one assertion of `rd_stb_i`, however many cycles it lasts, advances it exactly once.
- R5: The toggle is cleared at the start of each operation, so the first read of a new operation returns bit 6 = 0.
- R6: Bit 5 reads 0 while the operation is within its limit and 1 once `tmo_i` is seen during an operation. A `tmo_i` pulse while idle has no effect.
- R7: After a timeout, the status word stays on `rd_data_o` after `busy_i` falls, until `reset_cmd_i` is pulsed. The pulse returns the output to array data.
- R8: While status is shown, bits 15:8 and 4:0 of `rd_data_o` still carry `arr_data_i`.
- R9: After `rst_n` is released, the block is idle with the toggle cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Embedded algorithm running |
| op_erase_i | input | 1 | 1 = chip erase, 0 = word program (sampled at start) |
| tgt_d7_i | input | 1 | Bit 7 of the word being programmed (sampled at start) |
| tmo_i | input | 1 | Time limit exceeded |
| rd_stb_i | input | 1 | Read access strobe, active high by default |
| reset_cmd_i | input | 1 | Reset command decoded, one-cycle pulse |
| arr_data_i | input | DW | Array read data |
| rd_data_o | output | DW | Read data toward the bus |

## Verification
The bench builds the block with its defaults: DW = 16 and an active-high read strobe. With these, all eight pass-through bits above the polling bit and the five below the fail bit can be checked at once. A fixed table covers program and erase with both target polarities over differing array words. Directed sequences cover long strobes, restart of an operation with the toggle left at 1, an idle timeout pulse, and a failure that outlives `busy_i` until the reset command.

// File: rtl/pe_stat_pkg.sv
package pe_stat_pkg;
   localparam int unsigned POLL_POS = 7;
   localparam int unsigned TOGL_POS = 6;
   localparam int unsigned FAIL_POS = 5;
   localparam int unsigned MIN_DW   = 8;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_t;

   typedef struct packed {
      logic poll;
      logic togl;
      logic fail;
   } stat_bits_t;
endpackage

// File: rtl/pe_stat_strobe_edge.sv
module pe_stat_strobe_edge #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   output logic access_o
);
   logic lvl;
   logic lvl_q;

   generate
      if (ACTIVE_HIGH) begin : g_hi
         assign lvl = stb_i;
      end else begin : g_lo
         assign lvl = ~stb_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign access_o = lvl & ~lvl_q;

   // R4: one access per strobe assertion, never two in a row
   a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
      access_o |=> !access_o);
endmodule

// File: rtl/pe_stat_tracker.sv
module pe_stat_tracker
   import pe_stat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy_i,
   input  logic       op_erase_i,
   input  logic       tgt_d7_i,
   input  logic       tmo_i,
   input  logic       access_i,
   input  logic       reset_cmd_i,
   output logic       show_o,
   output stat_bits_t bits_o
);
   logic     busy_q;
   logic     start;
   logic     togl_q;
   logic     fail_q;
   logic     d7_q;
   op_kind_t kind_q;

   assign start  = busy_i & ~busy_q;
   assign show_o = busy_i | fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         togl_q <= 1'b0;
         fail_q <= 1'b0;
         d7_q   <= 1'b0;
         kind_q <= OP_PROGRAM;
      end else begin
         busy_q <= busy_i;
         if (start) begin
            togl_q <= 1'b0;
            fail_q <= 1'b0;
            d7_q   <= tgt_d7_i;
            kind_q <= op_kind_t'(op_erase_i);
         end else begin
            if (access_i && show_o) togl_q <= ~togl_q;
            if (busy_i && tmo_i)    fail_q <= 1'b1;
            else if (reset_cmd_i)   fail_q <= 1'b0;
         end
      end
   end

   assign bits_o.poll = (kind_q == OP_ERASE) ? 1'b0 : ~d7_q;
   assign bits_o.togl = togl_q;
   assign bits_o.fail = fail_q;

   // R5: a new operation begins with the toggle cleared
   a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !togl_q);
   // R4: a read access during status inverts the toggle
   a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (access_i && show_o && !start) |=> (togl_q != $past(togl_q)));
   // R6: a timeout pulse while idle leaves the fail flag low
   a_r6_idle_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !fail_q && !reset_cmd_i) |=> !fail_q);
   // R7: failure is held until a reset command or a new start
   a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_q && !reset_cmd_i && !start) |=> fail_q);
endmodule

// File: rtl/pe_stat_mux.sv
module pe_stat_mux
   import pe_stat_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          show_i,
   input  stat_bits_t    bits_i,
   input  logic [DW-1:0] arr_i,
   output logic [DW-1:0] data_o
);
   localparam int unsigned HI_W = DW - POLL_POS - 1;

   logic [FAIL_POS-1:0] lo_part;
   assign lo_part = arr_i[FAIL_POS-1:0];

   generate
      if (HI_W > 0) begin : g_hi
         always_comb begin
            data_o = arr_i;
            if (show_i)
               data_o = {arr_i[DW-1:POLL_POS+1], bits_i.poll, bits_i.togl, bits_i.fail, lo_part};
         end
      end else begin : g_nohi
         always_comb begin
            data_o = arr_i;
            if (show_i) data_o = {bits_i.poll, bits_i.togl, bits_i.fail, lo_part};
         end
      end
   endgenerate

   // R1: idle means pass-through
   a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !show_i |-> (data_o == arr_i));
   // R8: bits outside the status field follow the array
   a_r8_lo_pass: assert property (@(posedge clk) disable iff (!rst_n)
      show_i |-> (data_o[FAIL_POS-1:0] == arr_i[FAIL_POS-1:0]));
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
   import pe_stat_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter bit          STB_ACT_HI = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          op_erase_i,
   input  logic          tgt_d7_i,
   input  logic          tmo_i,
   input  logic          rd_stb_i,
   input  logic          reset_cmd_i,
   input  logic [DW-1:0] arr_data_i,
   output logic [DW-1:0] rd_data_o
);
   initial begin
      if (DW < MIN_DW) $error("pe_status_gen: DW must be at least %0d", MIN_DW);
   end

   logic       access;
   logic       show;
   stat_bits_t bits;

   pe_stat_strobe_edge #(.ACTIVE_HIGH(STB_ACT_HI)) u_edge (
      .clk(clk), .rst_n(rst_n), .stb_i(rd_stb_i), .access_o(access));

   pe_stat_tracker u_trk (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_erase_i(op_erase_i),
      .tgt_d7_i(tgt_d7_i), .tmo_i(tmo_i), .access_i(access),
      .reset_cmd_i(reset_cmd_i), .show_o(show), .bits_o(bits));

   pe_stat_mux #(.DW(DW)) u_mux (
      .clk(clk), .rst_n(rst_n), .show_i(show), .bits_i(bits),
      .arr_i(arr_data_i), .data_o(rd_data_o));

   // R3: erase polls as zero on bit 7
   a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i) && $past(op_erase_i) && $past(busy_i) != $past(busy_i, 2) && !bits.fail)
      |-> (rd_data_o[POLL_POS] == 1'b0));
endmodule

// File: tb/pe_status_gen_tb_top.sv
module pe_status_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy = 1'b0, op_erase = 1'b0, d7 = 1'b0, tmo = 1'b0, stb = 1'b0, rcmd = 1'b0;
   logic [15:0] arr = 16'h0000;
   logic [15:0] rd;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pe_status_gen dut_i (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op_erase),
      .tgt_d7_i(d7), .tmo_i(tmo), .rd_stb_i(stb), .reset_cmd_i(rcmd),
      .arr_data_i(arr), .rd_data_o(rd));

   // {op_erase, d7, arr}
   localparam logic [17:0] VEC [4] = '{
      {1'b0, 1'b0, 16'hA5C3},
      {1'b0, 1'b1, 16'h5A3C},
      {1'b1, 1'b0, 16'hFFFF},
      {1'b1, 1'b1, 16'h1234}};

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // read access lasting len cycles; returns word seen at strobe start
   task automatic rd_access(input int len, output logic [15:0] w);
      stb = 1'b1; #1 w = rd;
      cyc(len);
      stb = 1'b0;
      cyc(1);
   endtask

   task automatic start_op(input logic er, input logic t7);
      op_erase = er; d7 = t7; busy = 1'b1;
      cyc(2);
   endtask

   function automatic logic [15:0] stat_word(logic [15:0] a, logic p, logic t, logic f);
      return {a[15:8], p, t, f, a[4:0]};
   endfunction

   initial begin : wd
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      cyc(3);
      arr = 16'hC0DE;
      #1 chk("R9 reset output", rd, 16'hC0DE);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 idle pass", rd, 16'hC0DE);
      rd_access(1, w);
      chk("R1 idle read", w, 16'hC0DE);

      // table walk: polling bit, fail low, other bits pass
      foreach (VEC[i]) begin
         logic [15:0] a;
         a = VEC[i][15:0];
         arr = a;
         start_op(VEC[i][17], VEC[i][16]);
         rd_access(1, w);
         chk(VEC[i][17] ? "R3 erase poll" : "R2 program poll",
             w, stat_word(a, VEC[i][17] ? 1'b0 : ~VEC[i][16], 1'b0, 1'b0));
         d7 = ~d7; op_erase = ~op_erase; cyc(1);
         chk("R2 captured at start / R8", rd, stat_word(a, VEC[i][17] ? 1'b0 : ~VEC[i][16], 1'b1, 1'b0));
         busy = 1'b0; cyc(1);
         chk("R1 pass after done", rd, a);
      end

      // R4: long and short strobes each advance once
      arr = 16'h0F0F;
      start_op(1'b0, 1'b1);
      rd_access(5, w); chk("R4 read1 R5 first", w, stat_word(16'h0F0F, 1'b0, 1'b0, 1'b0));
      rd_access(1, w); chk("R4 read2", w, stat_word(16'h0F0F, 1'b0, 1'b1, 1'b0));
      arr = 16'hF0F0;
      rd_access(7, w); chk("R4 read3 addr change", w, stat_word(16'hF0F0, 1'b0, 1'b0, 1'b0));
      rd_access(1, w); chk("R4 read4", w, stat_word(16'hF0F0, 1'b0, 1'b1, 1'b0));
      // toggle now 0 -> read once more to leave it at 1, then restart
      rd_access(1, w);
      busy = 1'b0; cyc(2);
      start_op(1'b1, 1'b0);
      rd_access(1, w); chk("R5 restart clears toggle", w, stat_word(16'hF0F0, 1'b0, 1'b0, 1'b0));
      busy = 1'b0; cyc(2);

      // R6: idle timeout ignored
      tmo = 1'b1; cyc(1); tmo = 1'b0; cyc(1);
      chk("R6 idle tmo ignored", rd, 16'hF0F0);

      // R6/R7: timeout during operation
      arr = 16'h3377;
      start_op(1'b0, 1'b0);
      rd_access(1, w); chk("R6 within limit", w, stat_word(16'h3377, 1'b1, 1'b0, 1'b0));
      rcmd = 1'b1; cyc(1); rcmd = 1'b0;
      chk("R7 reset cmd no effect without fail", rd, stat_word(16'h3377, 1'b1, 1'b1, 1'b0));
      tmo = 1'b1; cyc(1); tmo = 1'b0;
      chk("R6 fail set", rd, stat_word(16'h3377, 1'b1, 1'b1, 1'b1));
      busy = 1'b0; cyc(3);
      chk("R7 held after busy low", rd, stat_word(16'h3377, 1'b1, 1'b1, 1'b1));
      rd_access(1, w); chk("R7 toggle while failed", w, stat_word(16'h3377, 1'b1, 1'b1, 1'b1));
      chk("R7 toggled", rd, stat_word(16'h3377, 1'b1, 1'b0, 1'b1));
      rcmd = 1'b1; cyc(1); rcmd = 1'b0;
      chk("R7 reset cmd returns array", rd, 16'h3377);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule